// File: doc/BRIEF.md
# FSM State-Transition Checker

This block is a small Moore-style finite state machine with a concurrent checker. The checker watches every state change as it happens. On each clock it takes the present-state code and the code about to be loaded into the state register, and decides whether that pair can be a move in the machine's transition graph. It does not keep a second copy of the machine. It only looks up whether the pair is legal.

The checker has two parts. The first flags a next-state code that belongs to no state. The state code is 5 bits wide for 5 states, so most codes belong to no state: the extra bits are there only to make such codes common. The second part flags a code that does belong to a state but cannot follow the present state under any input. A wrong move into another legal successor of the present state cannot be told apart from a correct move, so the flag stays low in that case. The verdict is registered and sticky until reset.

A fault-mask input XORs onto the next-state code just ahead of the state register. With it a test can create unassigned codes, non-successor codes and undetectable codes.

Top module: `fsmtc_top`

## Requirements
- R1: While reset is held low and right after it, state_code is 5'b00000 (state 0), fsm_out is 5'b00001 and err_flag is low.
- R2: The state codes are: state 0 = 00000, state 1 = 00111, state 2 = 11001, state 3 = 01110, state 4 = 10110. For fsm_in = 0/1/2/3 the next states are: state 0 → 0/1/2/0, state 1 → 1/3/3/0, state 2 → 2/4/0/4, state 3 → 3/4/4/3, state 4 → 4/0/0/0. With fault_mask zero, every one of these moves is taken on the next rising edge and err_flag stays low.
- R3: When the code loaded into the state register matches none of the five state codes, err_flag is high right after that edge.
- R4: When the loaded code is a state code, but that state cannot be reached from the present state under any fsm_in value, err_flag is high right after that edge.
- R5: When the loaded code is a legal successor of the present state other than the intended one, the state moves there and err_flag stays low.
- R6: The state register loads the computed next-state code XOR fault_mask, and state_code shows this value after the edge.
- R7: Once high, err_flag stays high through any later moves until reset is asserted.
- R8: The first state load after reset is released is not checked: a bad code loaded at that edge leaves err_flag low.
- R9: When the present code matches no state, the next state is state 0. The move out of such a code is counted as illegal and sets err_flag.
- R10: fsm_out bit i is high exactly when the present code equals the code of state i. It is all zeros when the present code matches no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsm_in | input | 2 | Input value of the machine |
| fault_mask | input | 5 | Test mask XORed onto the next-state code |
| state_code | output | 5 | Present contents of the state register |
| fsm_out | output | 5 | One-hot decode of the present state |
| err_flag | output | 1 | Sticky illegal-transition flag |

## Verification
The hardest cases to reach from the ports are the inner-checker hits and the undetectable moves. Both need the state register to hold an assigned code that the graph does not allow next.

The stimulus first steers the machine into a chosen present state along known legal paths. It then applies one input together with a mask picked so that the intended next code flips into a specific other state's code. The mask is chosen either to land on a non-successor or to land on one of the present state's own successors.

A separate directed case loads an unassigned code on the unchecked first edge after reset. This puts the machine in an invalid present state without the flag already being set.

// File: rtl/fsmtc_pkg.sv
package fsmtc_pkg;

  localparam int FSM_STATES = 5;
  localparam int FSM_IN_W   = 2;
  localparam int FSM_CODE_W = 5;
  localparam int FSM_IDX_W  = $clog2(FSM_STATES);

  // state i occupies bits [i*CODE_W +: CODE_W]
  localparam logic [FSM_STATES*FSM_CODE_W-1:0] DEF_CODES = {
    5'b10110,   // state 4
    5'b01110,   // state 3
    5'b11001,   // state 2
    5'b00111,   // state 1
    5'b00000    // state 0 (reset state)
  };

  // successor index of (state s, input x) at slot s*2^IN_W + x
  localparam logic [FSM_STATES*(1<<FSM_IN_W)*FSM_IDX_W-1:0] DEF_NEXT = {
    3'd0, 3'd0, 3'd0, 3'd4,   // state 4, x = 3..0
    3'd3, 3'd4, 3'd4, 3'd3,   // state 3
    3'd4, 3'd0, 3'd4, 3'd2,   // state 2
    3'd0, 3'd3, 3'd3, 3'd1,   // state 1
    3'd0, 3'd2, 3'd1, 3'd0    // state 0
  };

  typedef struct packed {
    logic outer;
    logic inner;
  } chk_hit_t;

endpackage

// File: rtl/fsmtc_code_match.sv
module fsmtc_code_match #(
  parameter int N = 5,
  parameter int W = 5,
  parameter logic [N*W-1:0] CODES = '0
) (
  input  logic [W-1:0] code,
  output logic [N-1:0] hit
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = (code == CODES[g*W +: W]);
  end

endmodule

// File: rtl/fsmtc_next_logic.sv
module fsmtc_next_logic #(
  parameter int N     = 5,
  parameter int IN_W  = 2,
  parameter int W     = 5,
  parameter int IDX_W = 3,
  parameter logic [N*W-1:0]                 CODES = '0,
  parameter logic [N*(1<<IN_W)*IDX_W-1:0]   NEXT_TABLE = '0
) (
  input  logic [N-1:0]    cur_hit,
  input  logic [IN_W-1:0] x,
  output logic [W-1:0]    next_code
);

  localparam int IN_CNT = 1 << IN_W;

  function automatic logic [W-1:0] lookup(input int s, input logic [IN_W-1:0] xi);
    int slot;
    int t;
    slot = s * IN_CNT + int'(xi);
    t    = int'(NEXT_TABLE[slot*IDX_W +: IDX_W]);
    return CODES[t*W +: W];
  endfunction

  always_comb begin
    next_code = CODES[0 +: W];   // unassigned present code falls back to state 0
    for (int g = 0; g < N; g++) begin
      if (cur_hit[g]) next_code = lookup(g, x);
    end
  end

endmodule

// File: rtl/fsmtc_txn_checker.sv
module fsmtc_txn_checker
  import fsmtc_pkg::*;
#(
  parameter int N     = 5,
  parameter int IN_W  = 2,
  parameter int IDX_W = 3,
  parameter logic [N*(1<<IN_W)*IDX_W-1:0] NEXT_TABLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cur_hit,
  input  logic [N-1:0] nxt_hit,
  output logic         outer_hit,
  output logic         inner_hit,
  output logic         armed,
  output logic         err_flag
);

  localparam int IN_CNT = 1 << IN_W;

  function automatic logic [N-1:0] successors(input int s);
    logic [N-1:0] r;
    int t;
    r = '0;
    for (int x = 0; x < IN_CNT; x++) begin
      t = int'(NEXT_TABLE[(s*IN_CNT + x)*IDX_W +: IDX_W]);
      r[t] = 1'b1;
    end
    return r;
  endfunction

  logic [N-1:0] succ_tab [N];
  for (genvar g = 0; g < N; g++) begin : g_succ
    localparam logic [N-1:0] SUCC = successors(g);
    assign succ_tab[g] = SUCC;
  end

  logic [N-1:0] cur_succ;
  always_comb begin
    cur_succ = '0;
    for (int g = 0; g < N; g++) begin
      if (cur_hit[g]) cur_succ = cur_succ | succ_tab[g];
    end
  end

  chk_hit_t hits;
  assign hits.outer = ~(|nxt_hit);
  assign hits.inner = (|nxt_hit) & ~(|(nxt_hit & cur_succ));
  assign outer_hit  = hits.outer;
  assign inner_hit  = hits.inner;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      armed    <= 1'b1;
      err_flag <= err_flag | (armed & (hits.outer | hits.inner));
    end
  end

endmodule

// File: rtl/fsmtc_top.sv
module fsmtc_top
  import fsmtc_pkg::*;
#(
  parameter int NUM_STATES = FSM_STATES,
  parameter int IN_W       = FSM_IN_W,
  parameter int CODE_W     = FSM_CODE_W,
  parameter logic [NUM_STATES*CODE_W-1:0] STATE_CODES = DEF_CODES,
  parameter logic [NUM_STATES*(1<<IN_W)*$clog2(NUM_STATES)-1:0] NEXT_TABLE = DEF_NEXT
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IN_W-1:0]       fsm_in,
  input  logic [CODE_W-1:0]     fault_mask,
  output logic [CODE_W-1:0]     state_code,
  output logic [NUM_STATES-1:0] fsm_out,
  output logic                  err_flag
);

  localparam int IDX_W = $clog2(NUM_STATES);

  logic [CODE_W-1:0]     state_q;
  logic [CODE_W-1:0]     next_code;
  logic [CODE_W-1:0]     next_inj;
  logic [NUM_STATES-1:0] cur_hit;
  logic [NUM_STATES-1:0] nxt_hit;
  logic                  outer_hit;
  logic                  inner_hit;
  logic                  chk_armed;

  fsmtc_code_match #(.N(NUM_STATES), .W(CODE_W), .CODES(STATE_CODES)) u_cur_match (
    .code (state_q),
    .hit  (cur_hit)
  );

  fsmtc_next_logic #(
    .N(NUM_STATES), .IN_W(IN_W), .W(CODE_W), .IDX_W(IDX_W),
    .CODES(STATE_CODES), .NEXT_TABLE(NEXT_TABLE)
  ) u_next (
    .cur_hit   (cur_hit),
    .x         (fsm_in),
    .next_code (next_code)
  );

  assign next_inj = next_code ^ fault_mask;

  fsmtc_code_match #(.N(NUM_STATES), .W(CODE_W), .CODES(STATE_CODES)) u_nxt_match (
    .code (next_inj),
    .hit  (nxt_hit)
  );

  fsmtc_txn_checker #(
    .N(NUM_STATES), .IN_W(IN_W), .IDX_W(IDX_W), .NEXT_TABLE(NEXT_TABLE)
  ) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_hit   (cur_hit),
    .nxt_hit   (nxt_hit),
    .outer_hit (outer_hit),
    .inner_hit (inner_hit),
    .armed     (chk_armed),
    .err_flag  (err_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= STATE_CODES[0 +: CODE_W];
    else        state_q <= next_inj;
  end

  assign state_code = state_q;
  assign fsm_out    = cur_hit;

endmodule

// File: rtl/fsmtc_sva.sv
module fsmtc_sva #(
  parameter int NUM_STATES = 5,
  parameter int CODE_W     = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [CODE_W-1:0]     fault_mask,
  input logic [CODE_W-1:0]     state_code,
  input logic [CODE_W-1:0]     next_inj,
  input logic [NUM_STATES-1:0] fsm_out,
  input logic                  outer_hit,
  input logic                  inner_hit,
  input logic                  chk_armed,
  input logic                  err_flag
);

  // R7: flag never drops while reset is released
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  // R3: a rising flag needs an armed detection in the prior cycle
  a_r3_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(chk_armed && (outer_hit || inner_hit)));

  // R2: a valid present state with no mask never reports a hit
  a_r2_clean_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    ((|fsm_out) && fault_mask == '0) |-> !(outer_hit || inner_hit));

  // R4: the two checker halves never fire together
  a_r4_halves_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(outer_hit && inner_hit));

  // R6: the register takes the masked next code
  a_r6_inject_lands: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> state_code == $past(next_inj));

  // R10: at most one state decode active
  a_r10_out_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fsm_out));

endmodule

bind fsmtc_top fsmtc_sva #(.NUM_STATES(NUM_STATES), .CODE_W(CODE_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .fault_mask (fault_mask),
  .state_code (state_code),
  .next_inj   (next_inj),
  .fsm_out    (fsm_out),
  .outer_hit  (outer_hit),
  .inner_hit  (inner_hit),
  .chk_armed  (chk_armed),
  .err_flag   (err_flag)
);

// File: tb/fsmtc_top_bench.sv
module fsmtc_top_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] fsm_in = 2'd0;
  logic [4:0] fault_mask = 5'd0;
  logic [4:0] state_code;
  logic [4:0] fsm_out;
  logic       err_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fsmtc_top u_fsmtc_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .fsm_in     (fsm_in),
    .fault_mask (fault_mask),
    .state_code (state_code),
    .fsm_out    (fsm_out),
    .err_flag   (err_flag)
  );

  localparam logic [4:0] BC [5] = '{5'b00000, 5'b00111, 5'b11001, 5'b01110, 5'b10110};

  // {src[15:13], x[12:11], mask[10:6], expected code[5:1], expected flag[0]}
  localparam int NV = 30;
  localparam logic [15:0] VEC [NV] = '{
    {3'd0, 2'd0, 5'b00000, 5'b00000, 1'b0},
    {3'd0, 2'd1, 5'b00000, 5'b00111, 1'b0},
    {3'd0, 2'd2, 5'b00000, 5'b11001, 1'b0},
    {3'd0, 2'd3, 5'b00000, 5'b00000, 1'b0},
    {3'd1, 2'd0, 5'b00000, 5'b00111, 1'b0},
    {3'd1, 2'd1, 5'b00000, 5'b01110, 1'b0},
    {3'd1, 2'd2, 5'b00000, 5'b01110, 1'b0},
    {3'd1, 2'd3, 5'b00000, 5'b00000, 1'b0},
    {3'd2, 2'd0, 5'b00000, 5'b11001, 1'b0},
    {3'd2, 2'd1, 5'b00000, 5'b10110, 1'b0},
    {3'd2, 2'd2, 5'b00000, 5'b00000, 1'b0},
    {3'd2, 2'd3, 5'b00000, 5'b10110, 1'b0},
    {3'd3, 2'd0, 5'b00000, 5'b01110, 1'b0},
    {3'd3, 2'd1, 5'b00000, 5'b10110, 1'b0},
    {3'd3, 2'd2, 5'b00000, 5'b10110, 1'b0},
    {3'd3, 2'd3, 5'b00000, 5'b01110, 1'b0},
    {3'd4, 2'd0, 5'b00000, 5'b10110, 1'b0},
    {3'd4, 2'd1, 5'b00000, 5'b00000, 1'b0},
    {3'd4, 2'd2, 5'b00000, 5'b00000, 1'b0},
    {3'd4, 2'd3, 5'b00000, 5'b00000, 1'b0},
    {3'd0, 2'd1, 5'b00001, 5'b00110, 1'b1},
    {3'd0, 2'd0, 5'b01110, 5'b01110, 1'b1},
    {3'd0, 2'd1, 5'b11110, 5'b11001, 1'b0},
    {3'd3, 2'd0, 5'b01110, 5'b00000, 1'b1},
    {3'd3, 2'd0, 5'b11000, 5'b10110, 1'b0},
    {3'd4, 2'd1, 5'b11111, 5'b11111, 1'b1},
    {3'd4, 2'd0, 5'b10001, 5'b00111, 1'b1},
    {3'd1, 2'd3, 5'b00111, 5'b00111, 1'b0},
    {3'd2, 2'd1, 5'b11000, 5'b01110, 1'b1},
    {3'd2, 2'd0, 5'b10000, 5'b01001, 1'b1}
  };

  function automatic bit is_assigned(input logic [4:0] c);
    for (int k = 0; k < 5; k++) if (BC[k] == c) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic [1:0] x, input logic [4:0] m);
    fsm_in     = x;
    fault_mask = m;
    @(negedge clk);
    fault_mask = 5'd0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    fsm_in = 2'd0;
    fault_mask = 5'd0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // reset, arm with one self-loop in state 0, then walk a legal path
  task automatic goto_state(input int s);
    do_reset();
    step(2'd0, 5'd0);
    case (s)
      1: step(2'd1, 5'd0);
      2: step(2'd2, 5'd0);
      3: begin step(2'd1, 5'd0); step(2'd1, 5'd0); end
      4: begin step(2'd2, 5'd0); step(2'd1, 5'd0); end
      default: ;
    endcase
  endtask

  initial begin
    // R1: reset state
    do_reset();
    check("R1", "state_code", {3'd0, state_code}, 8'h00);
    check("R1", "fsm_out", {3'd0, fsm_out}, 8'h01);
    check("R1", "err_flag", {7'd0, err_flag}, 8'h00);

    // table walk: R2 legal moves, R3/R4 detected faults, R5 hidden faults
    for (int i = 0; i < NV; i++) begin
      logic [4:0] dst;
      logic       ef;
      string      tag;
      dst = VEC[i][5:1];
      ef  = VEC[i][0];
      if (VEC[i][10:6] == 5'd0)  tag = "R2";
      else if (!ef)              tag = "R5";
      else if (!is_assigned(dst)) tag = "R3";
      else                       tag = "R4";
      goto_state(int'(VEC[i][15:13]));
      step(VEC[i][12:11], VEC[i][10:6]);
      check(tag, "state_code (R6)", {3'd0, state_code}, {3'd0, dst});
      check(tag, "err_flag", {7'd0, err_flag}, {7'd0, ef});
    end

    // R8: bad code on first edge after reset goes unchecked
    do_reset();
    step(2'd1, 5'b00001);
    check("R8", "err_flag", {7'd0, err_flag}, 8'h00);
    check("R8", "state_code", {3'd0, state_code}, 8'h06);
    check("R10", "fsm_out invalid", {3'd0, fsm_out}, 8'h00);
    // R9: leaving an unassigned code goes to state 0 and is flagged
    step(2'd2, 5'd0);
    check("R9", "state_code", {3'd0, state_code}, 8'h00);
    check("R9", "err_flag", {7'd0, err_flag}, 8'h01);
    check("R10", "fsm_out state0", {3'd0, fsm_out}, 8'h01);

    // R7: sticky through legal moves, cleared by reset
    step(2'd1, 5'd0);
    step(2'd1, 5'd0);
    check("R7", "err_flag held", {7'd0, err_flag}, 8'h01);
    check("R10", "fsm_out state3", {3'd0, fsm_out}, 8'h08);
    do_reset();
    check("R7", "err_flag cleared", {7'd0, err_flag}, 8'h00);

    // R10: decode in state 4
    goto_state(4);
    check("R10", "fsm_out state4", {3'd0, fsm_out}, 8'h10);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule